// File: doc/BRIEF.md
# Audio Codec Mixer Register File

This block is the bank of mixer control registers of a stereo audio codec. A host reaches it over a small 16-bit bus. Each access gives a 7-bit byte offset, and a write strobe or a read strobe qualifies it. The bank holds the following settings:

- volume and mute for the master output, the microphone input, the PCM output and the record path;
- a power-down word with read-only ready flags;
- an extended status/control word;
- three DAC sample-rate words: front, surround and LFE.

Downstream audio logic does not decode the bus words. It reads the settings from dedicated outputs: mute flags, raw attenuation and gain codes, and the front sample rate. Each master attenuation step stands for 1.5 dB.

Three offsets behave differently from plain storage:

- A write to offset 0x00 stores nothing. It is a partial reset that restores the sample rates to 48 kHz and clears the variable-rate enable.
- The capability, extended ID and vendor words are constants.
- Offsets with no register read as zero.

Read data is registered. It appears on the cycle after the read strobe and holds until the next read.

Top module: `codec_mixer_regs`

## Requirements
- R1: After reset these words read back as follows: 0x02 = 0x8000, 0x0E = 0x8008, 0x18 = 0x8808, 0x1C = 0x8000, 0x26 = 0x000F, 0x2A = 0x0000, and 0x2C, 0x2E and 0x30 each = 0xBB80.
- R2: The stereo words at 0x02 (master), 0x18 (PCM out) and 0x1C (record) store the mute flag in bit 15, the left code in bits 13:8 and the right code in bits 5:0. All other bits read 0.
- R3: The mic word at 0x0E stores the mute flag in bit 15, the 20 dB boost in bit 6 and the gain in bits 4:0, each independently. All other bits read 0.
- R4: At 0x26, a write replaces bits 15:4. Bits 3:0 are ready flags that always read 1.
- R5: The following offsets read constants, and writes to them change nothing:
  - 0x00 reads 0x0001 (dedicated mic present).
  - 0x28 reads 0x01C1: bit 0 variable rate, bit 6 center DAC, bit 7 surround DAC, bit 8 LFE DAC.
  - 0x7C and 0x7E read 0x5A1E.
- R6: The extended status/control word at 0x2A is fully writable, with the variable-rate enable in bit 0. The rate words at 0x2C (front), 0x2E (surround) and 0x30 (LFE) are fully writable 16-bit words.
- R7: A write of any data to 0x00 sets all three rate words to 0xBB80 and clears bit 0 of 0x2A. All other bits of 0x2A and every volume, mute and power-down setting stay unchanged.
- R8: Every offset not listed in R1 to R6, odd offsets included, reads 0. Writes to those offsets leave all stored state unchanged.
- R9: A read strobe at a clock edge puts the addressed word on rdata_o after that edge. Without a read strobe, rdata_o holds its value.
- R10: The decoded outputs follow the stored fields one cycle after a write. They are the master, PCM and record mutes with their left/right codes, the mic mute, boost and gain, and dac_rate_o, which equals the front rate word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 7 | Byte offset |
| wdata_i | input | 16 | Write data |
| we_i | input | 1 | Write strobe |
| re_i | input | 1 | Read strobe |
| rdata_o | output | 16 | Registered read data |
| master_mute_o | output | 1 | Master mute |
| master_att_l_o | output | 6 | Master left attenuation code |
| master_att_r_o | output | 6 | Master right attenuation code |
| pcm_mute_o | output | 1 | PCM-out mute |
| pcm_att_l_o | output | 6 | PCM-out left code |
| pcm_att_r_o | output | 6 | PCM-out right code |
| rec_mute_o | output | 1 | Record mute |
| rec_gain_l_o | output | 6 | Record left gain code |
| rec_gain_r_o | output | 6 | Record right gain code |
| mic_mute_o | output | 1 | Mic mute |
| mic_boost_o | output | 1 | Mic 20 dB boost |
| mic_gain_o | output | 5 | Mic gain code |
| dac_rate_o | output | 16 | Front DAC sample rate |

## Verification
The bench sweeps every even offset with eight data patterns. The patterns are all ones, all zeros, two checkerboards, two counting words and two edge-bit pairs, each XORed with the offset. Every write is read back immediately, and a full map sweep follows each pattern. All ones and the checkerboards separate the storage masks of the stereo, mic and power-down words. The edge-bit pairs show that a write does not disturb neighbouring registers and that stray bits in the holes read 0.

Writes to offset 0x00 that fall in the middle of each sweep show that the partial reset touches only the rates and bit 0. Odd offsets and holes in the map are checked for zero reads. A read issued during idle writes shows that the read data stays registered.

// File: rtl/mixr_pkg.sv
package mixr_pkg;
  localparam int AW = 7;
  localparam int DW = 16;
  localparam int VW = 6;
  localparam int MGW = 5;
  localparam int NRATE = 3;
  localparam int NSTEREO = 3;
  localparam int RDYW = 4;

  localparam logic [AW-1:0] OFS_CAPS   = 7'h00;
  localparam logic [AW-1:0] OFS_MASTER = 7'h02;
  localparam logic [AW-1:0] OFS_MIC    = 7'h0E;
  localparam logic [AW-1:0] OFS_PCM    = 7'h18;
  localparam logic [AW-1:0] OFS_REC    = 7'h1C;
  localparam logic [AW-1:0] OFS_PWR    = 7'h26;
  localparam logic [AW-1:0] OFS_XID    = 7'h28;
  localparam logic [AW-1:0] OFS_XCTL   = 7'h2A;
  localparam logic [AW-1:0] OFS_RATE_F = 7'h2C;
  localparam logic [AW-1:0] OFS_RATE_S = 7'h2E;
  localparam logic [AW-1:0] OFS_RATE_L = 7'h30;
  localparam logic [AW-1:0] OFS_VID1   = 7'h7C;
  localparam logic [AW-1:0] OFS_VID2   = 7'h7E;

  localparam logic [DW-1:0] CAPS_WORD = 16'h0001;
  localparam logic [DW-1:0] XID_WORD  = 16'h01C1;
  localparam logic [DW-1:0] VID_WORD  = 16'h5A1E;
  localparam logic [DW-1:0] RATE_48K  = 16'hBB80;

  typedef struct packed {
    logic          mute;
    logic [VW-1:0] l;
    logic [VW-1:0] r;
  } stereo_t;

  typedef struct packed {
    logic           mute;
    logic           boost;
    logic [MGW-1:0] gain;
  } mic_t;

  function automatic logic [DW-1:0] stereo_word(stereo_t s);
    return {s.mute, 1'b0, s.l, 2'b00, s.r};
  endfunction

  function automatic logic [DW-1:0] mic_word(mic_t m);
    return {m.mute, 8'h00, m.boost, 1'b0, m.gain};
  endfunction

  function automatic logic is_mapped(logic [AW-1:0] a);
    case (a)
      OFS_CAPS, OFS_MASTER, OFS_MIC, OFS_PCM, OFS_REC, OFS_PWR, OFS_XID,
      OFS_XCTL, OFS_RATE_F, OFS_RATE_S, OFS_RATE_L, OFS_VID1, OFS_VID2:
        return 1'b1;
      default: return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/mixr_stereo.sv
module mixr_stereo
  import mixr_pkg::*;
#(
  parameter logic          RST_MUTE = 1'b1,
  parameter logic [VW-1:0] RST_L    = '0,
  parameter logic [VW-1:0] RST_R    = '0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic          mute_i,
  input  logic [VW-1:0] l_i,
  input  logic [VW-1:0] r_i,
  output stereo_t       q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_o <= '{mute: RST_MUTE, l: RST_L, r: RST_R};
    end else if (wr_i) begin
      q_o <= '{mute: mute_i, l: l_i, r: r_i};
    end
  end

  // R2
  stereo_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> (q_o.mute == $past(mute_i)) && (q_o.l == $past(l_i)) && (q_o.r == $past(r_i)));
  // R8
  stereo_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(q_o));
endmodule

// File: rtl/mixr_rate_bank.sv
module mixr_rate_bank
  import mixr_pkg::*;
#(
  parameter int N = NRATE,
  parameter logic [DW-1:0] RST_RATE = RATE_48K
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [N-1:0]        wr_i,
  input  logic                restore_i,
  input  logic [DW-1:0]       wdata_i,
  output logic [N-1:0][DW-1:0] rate_o
);
  for (genvar g = 0; g < N; g++) begin : g_lane
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        rate_o[g] <= RST_RATE;
      else if (restore_i) rate_o[g] <= RST_RATE;
      else if (wr_i[g])   rate_o[g] <= wdata_i;
    end

    // R6
    rate_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_i[g] && !restore_i) |=> rate_o[g] == $past(wdata_i));
  end

  // R7
  rate_restore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restore_i |=> (rate_o == {N{RST_RATE}}));
endmodule

// File: rtl/mixr_rd_mux.sv
module mixr_rd_mux
  import mixr_pkg::*;
(
  input  logic [AW-1:0]           addr_i,
  input  stereo_t                 master_i,
  input  stereo_t                 pcm_i,
  input  stereo_t                 rec_i,
  input  mic_t                    mic_i,
  input  logic [DW-RDYW-1:0]      pwr_ctl_i,
  input  logic [DW-1:0]           xctl_i,
  input  logic [NRATE-1:0][DW-1:0] rate_i,
  output logic [DW-1:0]           word_o
);
  always_comb begin
    unique case (addr_i)
      OFS_CAPS:   word_o = CAPS_WORD;
      OFS_MASTER: word_o = stereo_word(master_i);
      OFS_MIC:    word_o = mic_word(mic_i);
      OFS_PCM:    word_o = stereo_word(pcm_i);
      OFS_REC:    word_o = stereo_word(rec_i);
      OFS_PWR:    word_o = {pwr_ctl_i, {RDYW{1'b1}}};
      OFS_XID:    word_o = XID_WORD;
      OFS_XCTL:   word_o = xctl_i;
      OFS_RATE_F: word_o = rate_i[0];
      OFS_RATE_S: word_o = rate_i[1];
      OFS_RATE_L: word_o = rate_i[2];
      OFS_VID1,
      OFS_VID2:   word_o = VID_WORD;
      default:    word_o = '0;
    endcase
  end
endmodule

// File: rtl/codec_mixer_regs.sv
module codec_mixer_regs
  import mixr_pkg::*;
(
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [AW-1:0]  addr_i,
  input  logic [DW-1:0]  wdata_i,
  input  logic           we_i,
  input  logic           re_i,
  output logic [DW-1:0]  rdata_o,
  output logic           master_mute_o,
  output logic [VW-1:0]  master_att_l_o,
  output logic [VW-1:0]  master_att_r_o,
  output logic           pcm_mute_o,
  output logic [VW-1:0]  pcm_att_l_o,
  output logic [VW-1:0]  pcm_att_r_o,
  output logic           rec_mute_o,
  output logic [VW-1:0]  rec_gain_l_o,
  output logic [VW-1:0]  rec_gain_r_o,
  output logic           mic_mute_o,
  output logic           mic_boost_o,
  output logic [MGW-1:0] mic_gain_o
  ,output logic [DW-1:0] dac_rate_o
);
  localparam logic [NSTEREO-1:0][AW-1:0] ST_OFS = {OFS_REC, OFS_PCM, OFS_MASTER};
  localparam logic [NSTEREO-1:0][VW-1:0] ST_RST = {6'd0, 6'd8, 6'd0};
  localparam logic [NRATE-1:0][AW-1:0]   RT_OFS = {OFS_RATE_L, OFS_RATE_S, OFS_RATE_F};

  stereo_t                   st_q [NSTEREO];
  mic_t                      mic_q;
  logic [DW-RDYW-1:0]        pwr_ctl_q;
  logic [DW-1:0]             xctl_q;
  logic [NRATE-1:0][DW-1:0]  rate_q;
  logic [NRATE-1:0]          rate_wr;
  logic                      restore;
  logic [DW-1:0]             rd_word;

  assign restore = we_i && (addr_i == OFS_CAPS);

  for (genvar g = 0; g < NSTEREO; g++) begin : g_st
    mixr_stereo #(.RST_MUTE(1'b1), .RST_L(ST_RST[g]), .RST_R(ST_RST[g])) u_st (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .wr_i   (we_i && (addr_i == ST_OFS[g])),
      .mute_i (wdata_i[15]),
      .l_i    (wdata_i[13:8]),
      .r_i    (wdata_i[5:0]),
      .q_o    (st_q[g])
    );
  end

  for (genvar g = 0; g < NRATE; g++) begin : g_rwr
    assign rate_wr[g] = we_i && (addr_i == RT_OFS[g]);
  end

  mixr_rate_bank #(.N(NRATE), .RST_RATE(RATE_48K)) u_rates (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (rate_wr),
    .restore_i (restore),
    .wdata_i   (wdata_i),
    .rate_o    (rate_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mic_q     <= '{mute: 1'b1, boost: 1'b0, gain: 5'd8};
      pwr_ctl_q <= '0;
      xctl_q    <= '0;
    end else if (we_i) begin
      unique case (addr_i)
        OFS_MIC:  mic_q <= '{mute: wdata_i[15], boost: wdata_i[6], gain: wdata_i[4:0]};
        OFS_PWR:  pwr_ctl_q <= wdata_i[DW-1:RDYW];
        OFS_XCTL: xctl_q <= wdata_i;
        OFS_CAPS: xctl_q[0] <= 1'b0; // partial reset drops variable-rate enable
        default: ;
      endcase
    end
  end

  mixr_rd_mux u_mux (
    .addr_i    (addr_i),
    .master_i  (st_q[0]),
    .pcm_i     (st_q[1]),
    .rec_i     (st_q[2]),
    .mic_i     (mic_q),
    .pwr_ctl_i (pwr_ctl_q),
    .xctl_i    (xctl_q),
    .rate_i    (rate_q),
    .word_o    (rd_word)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_o <= '0;
    else if (re_i) rdata_o <= rd_word;
  end

  assign master_mute_o  = st_q[0].mute;
  assign master_att_l_o = st_q[0].l;
  assign master_att_r_o = st_q[0].r;
  assign pcm_mute_o     = st_q[1].mute;
  assign pcm_att_l_o    = st_q[1].l;
  assign pcm_att_r_o    = st_q[1].r;
  assign rec_mute_o     = st_q[2].mute;
  assign rec_gain_l_o   = st_q[2].l;
  assign rec_gain_r_o   = st_q[2].r;
  assign mic_mute_o     = mic_q.mute;
  assign mic_boost_o    = mic_q.boost;
  assign mic_gain_o     = mic_q.gain;
  assign dac_rate_o     = rate_q[0];

  // R9
  rdata_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !re_i |=> $stable(rdata_o));
  // R8
  unmapped_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_i && !is_mapped(addr_i)) |=> rdata_o == '0);
  // R4
  pwr_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_i && addr_i == OFS_PWR) |=> rdata_o[RDYW-1:0] == {RDYW{1'b1}});
  // R7
  xctl_restore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restore |=> !xctl_q[0] && (xctl_q[DW-1:1] == $past(xctl_q[DW-1:1])));
  // R5
  const_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_i && addr_i == OFS_XID) |=> rdata_o == XID_WORD);
endmodule

// File: tb/codec_mixer_regs_test.sv
module codec_mixer_regs_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [6:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic        we = 1'b0, re = 1'b0;
  logic [15:0] rdata;
  logic        m_mute, p_mute, r_mute, mc_mute, mc_boost;
  logic [5:0]  m_l, m_r, p_l, p_r, r_l, r_r;
  logic [4:0]  mc_gain;
  logic [15:0] rate;

  int checks = 0, errors = 0;
  logic [15:0] mdl [64];  // expected word per even offset

  always #5 clk = ~clk;

  codec_mixer_regs uut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata), .we_i(we), .re_i(re),
    .rdata_o(rdata), .master_mute_o(m_mute), .master_att_l_o(m_l), .master_att_r_o(m_r),
    .pcm_mute_o(p_mute), .pcm_att_l_o(p_l), .pcm_att_r_o(p_r), .rec_mute_o(r_mute),
    .rec_gain_l_o(r_l), .rec_gain_r_o(r_r), .mic_mute_o(mc_mute), .mic_boost_o(mc_boost),
    .mic_gain_o(mc_gain), .dac_rate_o(rate));

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic string req_of(input logic [6:0] a);
    case (a)
      7'h02, 7'h18, 7'h1C: return "R2";
      7'h0E: return "R3";
      7'h26: return "R4";
      7'h00, 7'h28, 7'h7C, 7'h7E: return "R5";
      7'h2A, 7'h2C, 7'h2E, 7'h30: return "R6";
      default: return "R8";
    endcase
  endfunction

  function automatic logic [15:0] exp_rd(input logic [6:0] a);
    return a[0] ? 16'h0000 : mdl[a[6:1]];
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 64; i++) mdl[i] = 16'h0000;
    mdl[7'h00 >> 1] = 16'h0001; mdl[7'h02 >> 1] = 16'h8000; mdl[7'h0E >> 1] = 16'h8008;
    mdl[7'h18 >> 1] = 16'h8808; mdl[7'h1C >> 1] = 16'h8000; mdl[7'h26 >> 1] = 16'h000F;
    mdl[7'h28 >> 1] = 16'h01C1; mdl[7'h2A >> 1] = 16'h0000;
    mdl[7'h2C >> 1] = 16'hBB80; mdl[7'h2E >> 1] = 16'hBB80; mdl[7'h30 >> 1] = 16'hBB80;
    mdl[7'h7C >> 1] = 16'h5A1E; mdl[7'h7E >> 1] = 16'h5A1E;
  endtask

  task automatic model_write(input logic [6:0] a, input logic [15:0] d);
    if (a[0]) return;
    case (a)
      7'h00: begin
        mdl[7'h2C >> 1] = 16'hBB80; mdl[7'h2E >> 1] = 16'hBB80; mdl[7'h30 >> 1] = 16'hBB80;
        mdl[7'h2A >> 1][0] = 1'b0;
      end
      7'h02, 7'h18, 7'h1C: mdl[a[6:1]] = d & 16'hBF3F;
      7'h0E: mdl[a[6:1]] = d & 16'h805F;
      7'h26: mdl[a[6:1]] = (d & 16'hFFF0) | 16'h000F;
      7'h2A, 7'h2C, 7'h2E, 7'h30: mdl[a[6:1]] = d;
      default: ;
    endcase
  endtask

  task automatic wr(input logic [6:0] a, input logic [15:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
    model_write(a, d);
  endtask

  task automatic rd(input logic [6:0] a, output logic [15:0] d);
    @(negedge clk); addr = a; re = 1'b1;
    @(negedge clk); re = 1'b0; d = rdata;
  endtask

  task automatic sweep(input string tag);
    logic [15:0] d;
    for (int a = 0; a < 128; a += 2) begin
      rd(7'(a), d);
      chk(tag, d, exp_rd(7'(a)));
    end
  endtask

  task automatic chk_outs();
    logic [15:0] w;
    w = mdl[7'h02 >> 1];
    chk("R10 master", {m_mute, 1'b0, m_l, 2'b0, m_r}, w);
    w = mdl[7'h18 >> 1];
    chk("R10 pcm", {p_mute, 1'b0, p_l, 2'b0, p_r}, w);
    w = mdl[7'h1C >> 1];
    chk("R10 rec", {r_mute, 1'b0, r_l, 2'b0, r_r}, w);
    w = mdl[7'h0E >> 1];
    chk("R10 mic", {mc_mute, 8'h0, mc_boost, 1'b0, mc_gain}, w);
    chk("R10 rate", rate, mdl[7'h2C >> 1]);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    logic [15:0] d, prev;
    logic [15:0] pats [8];
    pats = '{16'hFFFF, 16'h0000, 16'hA5A5, 16'h5A5A, 16'h1234, 16'hEDCB, 16'h8001, 16'h7FFE};
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R9 reset rdata", rdata, 16'h0000);
    chk_outs();                       // R1 decoded defaults
    sweep("R1 reset defaults");

    foreach (pats[p]) begin
      for (int a = 0; a < 128; a += 2) begin
        wr(7'(a), pats[p] ^ {9'b0, 7'(a)});
        rd(7'(a), d);
        chk(req_of(7'(a)), d, exp_rd(7'(a)));
      end
      sweep("R8 full map after pattern");
      chk_outs();
    end

    // R8: odd offsets read zero and writes there leave state unchanged
    for (int a = 1; a < 128; a += 18) begin
      wr(7'(a), 16'hFFFF);
      rd(7'(a), d);
      chk("R8 odd offset", d, 16'h0000);
    end
    sweep("R8 odd writes ignored");

    // R7: partial reset
    wr(7'h2A, 16'hFFFF); wr(7'h2C, 16'h1F40); wr(7'h2E, 16'h2B11); wr(7'h30, 16'h3E80);
    wr(7'h02, 16'h0A15); wr(7'h26, 16'h1230);
    chk("R10 rate before restore", rate, 16'h1F40);
    wr(7'h00, 16'h0000);
    rd(7'h2A, d); chk("R7 vra cleared", d, 16'hFFFE);
    rd(7'h2C, d); chk("R7 front rate", d, 16'hBB80);
    rd(7'h2E, d); chk("R7 surround rate", d, 16'hBB80);
    rd(7'h30, d); chk("R7 lfe rate", d, 16'hBB80);
    rd(7'h02, d); chk("R7 master kept", d, 16'h0A15);
    rd(7'h26, d); chk("R7 pwr kept", d, 16'h123F);
    chk_outs();

    // R9: data appears only after the strobed edge and then holds
    rd(7'h02, prev);
    @(negedge clk); addr = 7'h28; re = 1'b1;
    #1 chk("R9 not before edge", rdata, prev);
    @(negedge clk); re = 1'b0;
    chk("R9 after edge", rdata, 16'h01C1);
    wr(7'h28, 16'h0000);
    wr(7'h02, 16'h8101);
    @(negedge clk); addr = 7'h02;
    @(negedge clk);
    chk("R9 hold without strobe", rdata, 16'h01C1);
    rd(7'h02, d); chk("R2 final", d, 16'h8101);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule